// File: doc/BRIEF.md
# Clock-Enable Controller with Power-of-Two Master Prescaler

This block turns three free-running source strobes (a slow strobe, a main-oscillator strobe and a PLL strobe), each one reference-clock cycle wide, into the enable pulses that the rest of the chip uses in place of separate clocks. A selectable source feeds a divide-by-2^n stage, and the result is the master enable. A processor enable follows the master enable but is held off while the processor is idle. Each peripheral has its own gated copy of the master enable. A fixed-source divider produces a USB enable from the PLL strobe. A bank of programmable enable outputs works like the master path, with a source and divider of its own.

Software reaches the block through a single-cycle write port and a combinational read port. A new source or divider setting is held as a request and applied only when the running divided interval ends, so no output interval is ever cut short. Each configurable path reports a ready bit that rises once its latest request has been applied. Entering idle is a register write. Any asserted `irq_pending` input ends idle.

Top module: `ckm_ctrl`

## Requirements
- R1: The master configuration lives at address 0. Bits [1:0] select the source: 0 slow, 1 main, 2 PLL, and 3 is also treated as PLL.
- R2: Bits [4:2] of the master configuration hold a divider code n, and the master enable then fires once every 2^n selected source pulses. Code 7 acts as code 6, giving /64.
- R3: A configuration written while an interval is running changes nothing until that interval ends. The interval in progress keeps its old length, and the next one uses the new setting.
- R4: Reading address 0 returns the last written setting in bits [4:0] and a ready bit in bit 5. Ready is 0 from the cycle after a write until the setting has been applied. After reset the master path runs on the slow source at /1 and address 0 reads 0x20.
- R5: Each master enable pulse lasts one cycle and comes one cycle after a source pulse.
- R6: A write to address 1 puts the processor in idle. Bit 0 of address 1 reads the idle state, and while idle the processor enable stays low even though the master enable keeps running.
- R7: An asserted `irq_pending` clears idle on the next edge. Outside idle the processor enable equals the master enable.
- R8: Writing a mask to address 2 switches on the peripheral enables whose bits are 1, and writing to address 3 switches off those whose bits are 1. Address 4 reads the enable mask, which is all zeros after reset. An enabled peripheral's output equals the master enable, and a disabled one stays low.
- R9: Address 5 bits [1:0] set the USB divider on the PLL strobe: 0 gives /1, 1 gives /2, and 2 or 3 give /4. Bit 5 of address 5 reads its ready flag.
- R10: Programmable output i is configured at address 8+i with the same field layout, source codes, divider codes and ready bit as the master path. It runs independently of the master path and of the other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_ce | input | 1 | Slow source strobe |
| main_ce | input | 1 | Main oscillator source strobe |
| pll_ce | input | 1 | PLL source strobe |
| irq_pending | input | 1 | Interrupt pending, ends idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Write address |
| wr_data | input | DW (32) | Write data |
| rd_addr | input | AW (4) | Read address |
| rd_data | output | DW (32) | Read data, combinational |
| mck_ce | output | 1 | Master clock enable |
| pck_ce | output | 1 | Processor clock enable |
| periph_ce | output | NPER (32) | Per-peripheral clock enables |
| usb_ce | output | 1 | USB clock enable |
| prog_ce | output | NPCK (4) | Programmable output enables |

## Verification
On every cycle the assertions check a fixed set of relations. Each master and USB pulse must follow a source pulse one cycle earlier. Processor and peripheral enables must never fire without the master enable. An interrupt must clear idle, a write to address 1 must silence the processor enable on the next cycle, and ready must drop after a write. Only the bench's scenarios can show the actual division ratios for each source and code, the full length of an interval that is running when a new setting is written, the mask arithmetic of set and clear, and the independence of the programmable outputs. Each of these needs interval lengths measured over many cycles.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
   // field layout shared by every configurable divider path
   localparam int SEL_W    = 2;
   localparam int CODE_W   = 3;
   localparam int SEL_LSB  = 0;
   localparam int CODE_LSB = 2;
   localparam int RDY_BIT  = 5;

   // register addresses
   localparam int A_MCFG  = 0;
   localparam int A_IDLE  = 1;
   localparam int A_PSET  = 2;
   localparam int A_PCLR  = 3;
   localparam int A_PSTAT = 4;
   localparam int A_USB   = 5;
   localparam int A_PROG0 = 8;

   typedef enum logic [SEL_W-1:0] {
      SRC_SLOW = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_PLL2 = 2'd3
   } ck_src_e;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [SEL_W-1:0]  sel;
   } ck_cfg_t;
endpackage

// File: rtl/ckm_divider.sv
module ckm_divider #(
   parameter int NSRC  = 3,
   parameter int SELW  = 2,
   parameter int CODEW = 3,
   parameter int MAXSH = 6,
   parameter logic [SELW-1:0]  RST_SEL  = '0,
   parameter logic [CODEW-1:0] RST_CODE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_ce,
   input  logic [SELW-1:0]  req_sel,
   input  logic [CODEW-1:0] req_code,
   input  logic             req_load,
   output logic             div_ce,
   output logic             ready
);
   localparam int CNTW = MAXSH;

   generate
      if (MAXSH < 1)
         $error("ckm_divider: MAXSH must be at least 1");
      if (NSRC > (1 << SELW))
         $error("ckm_divider: SELW too narrow for NSRC");
   endgenerate

   logic [SELW-1:0]  act_sel;
   logic [CODEW-1:0] act_code;
   logic             pend;
   logic [CNTW-1:0]  cnt;
   logic [CNTW-1:0]  lim;
   logic             hit;
   logic             last;
   logic             bnd;
   int               shamt;

   // source pick: codes past the last source fold onto the last one
   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (int'(act_sel) == i || (i == NSRC - 1 && int'(act_sel) >= NSRC))
            hit = src_ce[i];
      end
   end

   always_comb begin
      shamt = (int'(act_code) > MAXSH) ? MAXSH : int'(act_code);
      lim   = {CNTW{1'b1}} >> (CNTW - shamt);
      last  = (cnt == lim);
      bnd   = hit & last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel  <= RST_SEL;
         act_code <= RST_CODE;
         pend     <= 1'b0;
         cnt      <= '0;
         div_ce   <= 1'b0;
      end else begin
         div_ce <= bnd;
         if (hit)
            cnt <= last ? '0 : cnt + 1'b1;
         if (bnd && pend) begin
            act_sel  <= req_sel;
            act_code <= req_code;
         end
         if (req_load)
            pend <= 1'b1;
         else if (bnd)
            pend <= 1'b0;
      end
   end

   assign ready = ~pend;
endmodule

// File: rtl/ckm_idle_gate.sv
module ckm_idle_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req,
   input  logic irq_pending,
   input  logic mck_ce,
   output logic pck_ce,
   output logic idle_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_q <= 1'b0;
      else
         idle_q <= (idle_q | idle_req) & ~irq_pending;
   end

   assign pck_ce = mck_ce & ~idle_q;
endmodule

// File: rtl/ckm_periph_en.sv
module ckm_periph_en #(
   parameter int NPER = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_we,
   input  logic            clr_we,
   input  logic [NPER-1:0] mask,
   input  logic            mck_ce,
   output logic [NPER-1:0] en_q,
   output logic [NPER-1:0] periph_ce
);
   generate
      for (genvar g = 0; g < NPER; g++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               en_q[g] <= 1'b0;
            else if (set_we && mask[g])
               en_q[g] <= 1'b1;
            else if (clr_we && mask[g])
               en_q[g] <= 1'b0;
         end
         assign periph_ce[g] = en_q[g] & mck_ce;
      end
   endgenerate
endmodule

// File: rtl/ckm_ctrl.sv
module ckm_ctrl
   import ckm_pkg::*;
#(
   parameter int DW        = 32,
   parameter int AW        = 4,
   parameter int NPER      = 32,
   parameter int NPCK      = 4,
   parameter int MAXSH     = 6,
   parameter int USB_MAXSH = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_ce,
   input  logic            main_ce,
   input  logic            pll_ce,
   input  logic            irq_pending,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [AW-1:0]   rd_addr,
   output logic [DW-1:0]   rd_data,
   output logic            mck_ce,
   output logic            pck_ce,
   output logic [NPER-1:0] periph_ce,
   output logic            usb_ce,
   output logic [NPCK-1:0] prog_ce
);
   localparam int NSRC = 3;

   generate
      if (AW < 4)                     $error("ckm_ctrl: AW must be at least 4");
      if (NPCK < 1 || NPCK > 8)       $error("ckm_ctrl: NPCK out of range");
      if (NPER < 1 || NPER > DW)      $error("ckm_ctrl: NPER must fit DW");
      if (DW <= RDY_BIT)              $error("ckm_ctrl: DW too small");
      if (MAXSH > (1 << CODE_W) - 1)  $error("ckm_ctrl: MAXSH exceeds code range");
   endgenerate

   logic [NSRC-1:0] src_vec;
   assign src_vec = {pll_ce, main_ce, slow_ce};

   // write strobes
   logic we_mcfg, we_idle, we_pset, we_pclr, we_usb;
   logic [NPCK-1:0] we_prog;

   always_comb begin
      we_mcfg = wr_en && (wr_addr == AW'(A_MCFG));
      we_idle = wr_en && (wr_addr == AW'(A_IDLE));
      we_pset = wr_en && (wr_addr == AW'(A_PSET));
      we_pclr = wr_en && (wr_addr == AW'(A_PCLR));
      we_usb  = wr_en && (wr_addr == AW'(A_USB));
      for (int i = 0; i < NPCK; i++)
         we_prog[i] = wr_en && (wr_addr == AW'(A_PROG0 + i));
   end

   // requested settings
   ck_cfg_t    mcfg_req;
   ck_cfg_t    prog_req [NPCK];
   logic [1:0] usb_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcfg_req <= '{code: '0, sel: SRC_SLOW};
         usb_req  <= '0;
         for (int i = 0; i < NPCK; i++)
            prog_req[i] <= '{code: '0, sel: SRC_SLOW};
      end else begin
         if (we_mcfg) begin
            mcfg_req.sel  <= wr_data[SEL_LSB +: SEL_W];
            mcfg_req.code <= wr_data[CODE_LSB +: CODE_W];
         end
         if (we_usb)
            usb_req <= wr_data[1:0];
         for (int i = 0; i < NPCK; i++) begin
            if (we_prog[i]) begin
               prog_req[i].sel  <= wr_data[SEL_LSB +: SEL_W];
               prog_req[i].code <= wr_data[CODE_LSB +: CODE_W];
            end
         end
      end
   end

   // master path
   logic mck_ready;

   ckm_divider #(
      .NSRC(NSRC), .SELW(SEL_W), .CODEW(CODE_W), .MAXSH(MAXSH),
      .RST_SEL(SRC_SLOW), .RST_CODE('0)
   ) u_mdiv (
      .clk(clk), .rst_n(rst_n), .src_ce(src_vec),
      .req_sel(mcfg_req.sel), .req_code(mcfg_req.code), .req_load(we_mcfg),
      .div_ce(mck_ce), .ready(mck_ready)
   );

   // USB path: PLL only, 2-bit code folds 3 onto the top ratio
   logic usb_ready;

   ckm_divider #(
      .NSRC(1), .SELW(1), .CODEW(2), .MAXSH(USB_MAXSH),
      .RST_SEL(1'b0), .RST_CODE(2'd0)
   ) u_udiv (
      .clk(clk), .rst_n(rst_n), .src_ce(pll_ce),
      .req_sel(1'b0), .req_code(usb_req), .req_load(we_usb),
      .div_ce(usb_ce), .ready(usb_ready)
   );

   // programmable outputs
   logic [NPCK-1:0] prog_ready;

   generate
      for (genvar g = 0; g < NPCK; g++) begin : g_prog
         ckm_divider #(
            .NSRC(NSRC), .SELW(SEL_W), .CODEW(CODE_W), .MAXSH(MAXSH),
            .RST_SEL(SRC_SLOW), .RST_CODE('0)
         ) u_pdiv (
            .clk(clk), .rst_n(rst_n), .src_ce(src_vec),
            .req_sel(prog_req[g].sel), .req_code(prog_req[g].code),
            .req_load(we_prog[g]),
            .div_ce(prog_ce[g]), .ready(prog_ready[g])
         );
      end
   endgenerate

   // processor gate
   logic idle_q;

   ckm_idle_gate u_idle (
      .clk(clk), .rst_n(rst_n), .idle_req(we_idle),
      .irq_pending(irq_pending), .mck_ce(mck_ce),
      .pck_ce(pck_ce), .idle_q(idle_q)
   );

   // peripheral enables
   logic [NPER-1:0] pen_q;

   ckm_periph_en #(.NPER(NPER)) u_pen (
      .clk(clk), .rst_n(rst_n), .set_we(we_pset), .clr_we(we_pclr),
      .mask(wr_data[NPER-1:0]), .mck_ce(mck_ce),
      .en_q(pen_q), .periph_ce(periph_ce)
   );

   // read port
   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(A_MCFG)) begin
         rd_data[SEL_LSB +: SEL_W]   = mcfg_req.sel;
         rd_data[CODE_LSB +: CODE_W] = mcfg_req.code;
         rd_data[RDY_BIT]            = mck_ready;
      end else if (rd_addr == AW'(A_IDLE)) begin
         rd_data[0] = idle_q;
      end else if (rd_addr == AW'(A_PSTAT)) begin
         rd_data[NPER-1:0] = pen_q;
      end else if (rd_addr == AW'(A_USB)) begin
         rd_data[1:0]     = usb_req;
         rd_data[RDY_BIT] = usb_ready;
      end else begin
         for (int i = 0; i < NPCK; i++) begin
            if (rd_addr == AW'(A_PROG0 + i)) begin
               rd_data[SEL_LSB +: SEL_W]   = prog_req[i].sel;
               rd_data[CODE_LSB +: CODE_W] = prog_req[i].code;
               rd_data[RDY_BIT]            = prog_ready[i];
            end
         end
      end
   end
endmodule

// File: rtl/ckm_ctrl_chk.sv
module ckm_ctrl_chk #(
   parameter int NPER = 32,
   parameter int AW   = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            slow_ce,
   input logic            main_ce,
   input logic            pll_ce,
   input logic            irq_pending,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic            mck_ce,
   input logic            pck_ce,
   input logic [NPER-1:0] periph_ce,
   input logic            usb_ce,
   input logic            idle_q,
   input logic            mck_ready
);
   AST_MCK_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      mck_ce |-> $past(slow_ce | main_ce | pll_ce));                       // R5

   AST_USB_FROM_PLL: assert property (@(posedge clk) disable iff (!rst_n)
      usb_ce |-> $past(pll_ce));                                            // R9

   AST_PCK_IN_MCK: assert property (@(posedge clk) disable iff (!rst_n)
      pck_ce |-> mck_ce);                                                   // R7

   AST_PERIPH_IN_MCK: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_ce) |-> mck_ce);                                             // R8

   AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |=> !idle_q);                                             // R7

   AST_IDLE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(1) && !irq_pending) |=> !pck_ce);            // R6

   AST_NOT_READY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(0)) |=> !mck_ready);                         // R4
endmodule

bind ckm_ctrl ckm_ctrl_chk #(.NPER(NPER), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .main_ce(main_ce),
   .pll_ce(pll_ce), .irq_pending(irq_pending), .wr_en(wr_en),
   .wr_addr(wr_addr), .mck_ce(mck_ce), .pck_ce(pck_ce),
   .periph_ce(periph_ce), .usb_ce(usb_ce), .idle_q(idle_q),
   .mck_ready(mck_ready)
);

// File: tb/ckm_ctrl_tb.sv
module ckm_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int NPER = 32;
   localparam int NPCK = 4;
   localparam int P_SLOW = 20;
   localparam int P_MAIN = 6;
   localparam int P_PLL  = 2;

   // stimulus table: source code, divider code, expected master interval
   localparam int TBL_N = 8;
   localparam int TSEL [TBL_N] = '{0, 1, 1, 2, 3, 2, 1, 0};
   localparam int TCODE[TBL_N] = '{1, 0, 3, 2, 1, 7, 6, 2};
   localparam int TPER [TBL_N] = '{40, 6, 48, 8, 4, 128, 384, 80};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow_ce = 1'b0, main_ce = 1'b0, pll_ce = 1'b0;
   logic irq_pending = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic mck_ce, pck_ce, usb_ce;
   logic [NPER-1:0] periph_ce;
   logic [NPCK-1:0] prog_ce;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ckm_ctrl #(.DW(DW), .AW(AW), .NPER(NPER), .NPCK(NPCK)) u_dut (
      .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .main_ce(main_ce),
      .pll_ce(pll_ce), .irq_pending(irq_pending), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .mck_ce(mck_ce), .pck_ce(pck_ce),
      .periph_ce(periph_ce), .usb_ce(usb_ce), .prog_ce(prog_ce)
   );

   // source strobes, driven away from the active edge
   int cs = 0, cm = 0, cp = 0;
   always @(negedge clk) begin
      cs = (cs + 1) % P_SLOW;
      cm = (cm + 1) % P_MAIN;
      cp = (cp + 1) % P_PLL;
      slow_ce <= (cs == 0);
      main_ce <= (cm == 0);
      pll_ce  <= (cp == 0);
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic sig(input int w);
      case (w)
         0: return mck_ce;
         1: return usb_ce;
         2: return prog_ce[0];
         3: return prog_ce[1];
         default: return pck_ce;
      endcase
   endfunction

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = AW'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic wait_pulse(input int w);
      do @(negedge clk); while (!sig(w));
   endtask

   task automatic measure(input int w, output int per);
      wait_pulse(w);
      per = 0;
      do begin @(negedge clk); per++; end while (!sig(w));
   endtask

   task automatic wait_ready(input int a);
      int v;
      for (int k = 0; k < 3000; k++) begin
         rd(a, v);
         if (v[5]) return;
         @(negedge clk);
      end
   endtask

   task automatic count_window(input int n, output int nm, output int np,
                               output int n0, output int n2);
      nm = 0; np = 0; n0 = 0; n2 = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         nm += int'(mck_ce); np += int'(pck_ce);
         n0 += int'(periph_ce[0]); n2 += int'(periph_ce[2]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int v, per, nm, np, n0, n2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(0, v);  check("R4 reset master cfg", v, 32'h20);
      rd(4, v);  check("R8 reset periph mask", v, 0);
      rd(1, v);  check("R6 reset idle", v, 0);
      measure(0, per); check("R5 reset slow /1 interval", per, P_SLOW);

      // table walk over source and divider codes
      for (int t = 0; t < TBL_N; t++) begin
         wr(0, (TCODE[t] << 2) | TSEL[t]);
         wait_ready(0);
         measure(0, per);
         check($sformatf("R1 R2 sel %0d code %0d", TSEL[t], TCODE[t]), per, TPER[t]);
      end

      // ready drops right after a write, running interval is not cut
      wr(0, (1 << 2) | 0);          // slow /2
      rd(0, v); check("R4 ready low after write", v, 32'h04);
      wait_ready(0);
      wait_pulse(0);
      per = 0;
      repeat (5) begin @(negedge clk); per++; end
      wr(0, 2);                     // PLL /1
      per++;
      do begin @(negedge clk); per++; end while (!mck_ce);
      check("R3 interval in progress keeps old length", per, 40);
      measure(0, per); check("R3 next interval uses new setting", per, 2);
      rd(0, v); check("R4 ready after apply", v, 32'h22);

      // peripherals
      wr(2, 5);  rd(4, v); check("R8 set mask", v, 5);
      wr(3, 1);  rd(4, v); check("R8 clear mask", v, 4);
      count_window(40, nm, np, n0, n2);
      check("R8 enabled peripheral follows master", n2, nm);
      check("R8 disabled peripheral silent", n0, 0);

      // idle and wake
      wr(1, 1);  rd(1, v); check("R6 idle state", v, 1);
      count_window(40, nm, np, n0, n2);
      check("R6 processor silent in idle", np, 0);
      check("R6 master keeps running in idle", nm, 20);
      irq_pending = 1'b1; @(negedge clk); irq_pending = 1'b0;
      rd(1, v); check("R7 interrupt ends idle", v, 0);
      count_window(40, nm, np, n0, n2);
      check("R7 processor follows master after wake", np, nm);

      // USB divider
      for (int c = 0; c < 4; c++) begin
         wr(5, c);
         wait_ready(5);
         measure(1, per);
         check($sformatf("R9 usb code %0d", c), per, (c >= 2) ? 8 : (P_PLL << c));
      end

      // programmable outputs
      wr(8, (2 << 2) | 1);          // main /4
      wait_ready(8);
      wr(9, 2);                     // PLL /1
      wait_ready(9);
      measure(2, per); check("R10 output 0 main /4", per, 24);
      measure(3, per); check("R10 output 1 PLL /1", per, 2);
      measure(0, per); check("R10 master untouched", per, 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule